// File: doc/BRIEF.md
# Burst Transmit Power Ramp and Outer Control Loop

This block is the digital outer power loop of a burst-mode GSM/EDGE transmitter. A burst trigger starts it. It shapes the rising edge of the burst by stepping a ramp DAC code through a quadratic profile. During the burst body it corrects power from power-detector samples, and when the burst is stopped or aborted it shapes the falling edge back to zero. Each detector sample, marked by `det_valid`, is one sample tick. The ramp profile moves one step per tick, and the loop makes one correction per tick.

The modulation is latched when a burst starts and sets the control strategy. In phase-only (GMSK) mode the amplifier drive stays fixed and power is set through the ramp/bias code alone. The detector error integrates into that code with a programmable right-shift gain. In 8PSK mode the ramp code settles at a fixed DC level. Power is then trimmed by a 4-bit input step attenuator of 3 dB per step, covering 0 to 45 dB, which moves one step per tick in the direction that brings the detector reading to the target.

Top module: `burst_pwr_loop`

## Requirements
- R1: While `rst_n` is low and after it is released, `loop_state` is 0, `ramp_code` is 0, `atten_code` is 0 and `mode_active` is 0.
- R2: `loop_state` encodes idle=0, ramp-up=1, hold=2, ramp-down=3. `burst_start` moves idle to ramp-up in the next cycle and is ignored in every other state.
- R3: In ramp-up, the k-th tick (k=0..15) sets `ramp_code` to floor(P*(k+1)^2/256). P is 600 in GMSK and 512 in 8PSK. The 16th tick also enters hold.
- R4: A stop in hold, or an abort in ramp-up or hold, captures the present `ramp_code` as C and enters ramp-down with no other change. The next ticks give floor(C*(j+1)^2/256) for j=14 down to 0. One more tick then gives 0 and returns to idle.
- R5: In GMSK hold, each tick sets `ramp_code` to `ramp_code` + ((`target_code` - `det_sample`) arithmetically shifted right by `gain_shift`), clamped to 0..1023.
- R6: In 8PSK hold, `ramp_code` stays 512. On each tick `atten_code` rises by 1 when `det_sample` > `target_code`, falls by 1 when it is lower, and is unchanged when they are equal. It saturates at 15 and at 0, and each LSB is 3 dB.
- R7: `burst_start` clears `atten_code` to 0. In a GMSK burst it stays 0.
- R8: `mod_8psk` (1 = 8PSK, 0 = GMSK) is sampled only by an accepted `burst_start` and shown on `mode_active`. Changes at other times have no effect.
- R9: A stop or abort in the same cycle as a tick takes the transition, and that tick does not change `ramp_code` or `atten_code`. Stop in ramp-up, and stop or abort in idle or ramp-down, are ignored.
- R10: Without a tick, `ramp_code` and `atten_code` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Burst start pulse |
| burst_stop | input | 1 | Normal burst end pulse |
| burst_abort | input | 1 | Abort pulse, ends the burst through ramp-down |
| mod_8psk | input | 1 | Modulation select, 1 = 8PSK |
| gain_shift | input | 3 | Loop gain as right shift of the error |
| target_code | input | 10 | Target detector level |
| det_valid | input | 1 | Detector sample tick |
| det_sample | input | 10 | Detector ADC sample |
| ramp_code | output | 10 | Ramp DAC code |
| atten_code | output | 4 | Input step attenuator code, 3 dB per LSB |
| loop_state | output | 2 | Sequencer state |
| mode_active | output | 1 | Latched modulation, 1 = 8PSK |

## Verification
Within one cycle, an end-of-burst event (stop or abort) can fall together with a detector tick that would otherwise step the ramp profile, integrate the error, or step the attenuator. The bench raises `burst_stop` with `det_valid` during GMSK hold, and `burst_abort` with `det_valid` in the middle of ramp-up. It then checks that the next cycle shows ramp-down with `ramp_code` and `atten_code` unchanged. It also checks that the following ticks descend from the captured code rather than from a value the tick would have produced.

// File: rtl/bpr_pkg.sv
// Shared types of the burst power ramp loop.
package bpr_pkg;
    // Sequencer states; encoding is visible on loop_state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_HOLD = 2'd2,
        ST_DOWN = 2'd3
    } ramp_state_t;
endpackage

// File: rtl/bpr_shape.sv
// Quadratic ramp profile: level = floor(base * (idx+1)^2 / STEPS^2).
// Assumes idx < STEPS; the last index returns base exactly.
module bpr_shape #(
    parameter int DAC_W = 10,
    parameter int STEPS = 16,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic [DAC_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    output logic [DAC_W-1:0] level
);
    localparam int PROD_W = DAC_W + 2 * IDX_W + 4;
    localparam logic [PROD_W-1:0] DIV = PROD_W'(STEPS * STEPS);

    logic [PROD_W-1:0] k1;
    logic [PROD_W-1:0] prod;

    // Scale the base by the squared step number.
    always_comb begin
        k1    = PROD_W'(idx) + PROD_W'(1);
        prod  = PROD_W'(base) * k1 * k1;
        level = DAC_W'(prod / DIV);
    end
endmodule

// File: rtl/bpr_integ.sv
// GMSK loop integrator: cur + ((target - det) >>> shift), clamped to 0..full scale.
// Assumes unsigned inputs; the internal width holds any sum without wrap.
module bpr_integ #(
    parameter int DAC_W   = 10,
    parameter int ADC_W   = 10,
    parameter int SHIFT_W = 3
) (
    input  logic [DAC_W-1:0]   cur,
    input  logic [ADC_W-1:0]   target,
    input  logic [ADC_W-1:0]   det,
    input  logic [SHIFT_W-1:0] shift,
    output logic [DAC_W-1:0]   next
);
    localparam int SUM_W = ((DAC_W > ADC_W) ? DAC_W : ADC_W) + 2;
    localparam logic signed [SUM_W-1:0] FULL_S = SUM_W'((1 << DAC_W) - 1);

    logic signed [SUM_W-1:0] err;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum;

    // Error, gain shift, accumulate and clamp.
    always_comb begin
        err  = $signed(SUM_W'(target)) - $signed(SUM_W'(det));
        step = err >>> shift;
        sum  = $signed(SUM_W'(cur)) + step;
        if (sum < 0)
            next = '0;
        else if (sum > FULL_S)
            next = {DAC_W{1'b1}};
        else
            next = sum[DAC_W-1:0];
    end
endmodule

// File: rtl/bpr_atten.sv
// 8PSK attenuator stepper: one step toward the target per call, saturating.
// Larger code means more attenuation, so a high detector reading raises it.
module bpr_atten #(
    parameter int ATT_W = 4,
    parameter int ADC_W = 10
) (
    input  logic [ATT_W-1:0] cur,
    input  logic [ADC_W-1:0] target,
    input  logic [ADC_W-1:0] det,
    output logic [ATT_W-1:0] next
);
    localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

    // Compare and step by one within 0..ATT_MAX.
    always_comb begin
        if (det > target && cur != ATT_MAX)
            next = cur + 1'b1;
        else if (det < target && cur != '0)
            next = cur - 1'b1;
        else
            next = cur;
    end
endmodule

// File: rtl/burst_pwr_loop.sv
// Burst power ramp sequencer with the digital outer power loop.
// Shapes ramp-up and ramp-down per detector tick, closes the loop on the
// ramp code in GMSK and on the input attenuator in 8PSK.
// Assumes start/stop/abort are single-cycle pulses in the clk domain.
module burst_pwr_loop #(
    parameter int DAC_W     = 10,
    parameter int ADC_W     = 10,
    parameter int ATT_W     = 4,
    parameter int SHIFT_W   = 3,
    parameter int STEPS     = 16,
    parameter int GMSK_PEAK = 600,
    parameter int PSK_DC    = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               burst_start,
    input  logic               burst_stop,
    input  logic               burst_abort,
    input  logic               mod_8psk,
    input  logic [SHIFT_W-1:0] gain_shift,
    input  logic [ADC_W-1:0]   target_code,
    input  logic               det_valid,
    input  logic [ADC_W-1:0]   det_sample,
    output logic [DAC_W-1:0]   ramp_code,
    output logic [ATT_W-1:0]   atten_code,
    output logic [1:0]         loop_state,
    output logic               mode_active
);
    import bpr_pkg::*;

    localparam int IDX_W = $clog2(STEPS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

    ramp_state_t        st_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DAC_W-1:0]   base_q;
    logic [DAC_W-1:0]   ramp_q;
    logic [ATT_W-1:0]   att_q;
    logic               mode_q;

    logic [IDX_W-1:0]   shape_idx;
    logic [DAC_W-1:0]   shape_lvl;
    logic [DAC_W-1:0]   loop_next;
    logic [ATT_W-1:0]   att_next;

    // Ramp-down reads one profile entry below the current index.
    always_comb shape_idx = (st_q == ST_DOWN) ? idx_q - 1'b1 : idx_q;

    bpr_shape #(.DAC_W(DAC_W), .STEPS(STEPS)) u_shape (
        .base  (base_q),
        .idx   (shape_idx),
        .level (shape_lvl)
    );

    bpr_integ #(.DAC_W(DAC_W), .ADC_W(ADC_W), .SHIFT_W(SHIFT_W)) u_integ (
        .cur    (ramp_q),
        .target (target_code),
        .det    (det_sample),
        .shift  (gain_shift),
        .next   (loop_next)
    );

    bpr_atten #(.ATT_W(ATT_W), .ADC_W(ADC_W)) u_atten (
        .cur    (att_q),
        .target (target_code),
        .det    (det_sample),
        .next   (att_next)
    );

    // Sequencer: burst phases, profile stepping and per-tick loop updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            base_q <= '0;
            ramp_q <= '0;
            att_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (burst_start) begin
                        st_q   <= ST_UP;
                        idx_q  <= '0;
                        mode_q <= mod_8psk;
                        base_q <= mod_8psk ? DAC_W'(PSK_DC) : DAC_W'(GMSK_PEAK);
                        att_q  <= '0;
                    end
                end
                ST_UP: begin
                    if (burst_abort) begin
                        st_q   <= ST_DOWN;
                        base_q <= ramp_q;
                        idx_q  <= LAST;
                    end else if (det_valid) begin
                        ramp_q <= shape_lvl;
                        if (idx_q == LAST)
                            st_q <= ST_HOLD;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (burst_stop || burst_abort) begin
                        st_q   <= ST_DOWN;
                        base_q <= ramp_q;
                        idx_q  <= LAST;
                    end else if (det_valid) begin
                        if (mode_q)
                            att_q <= att_next;
                        else
                            ramp_q <= loop_next;
                    end
                end
                default: begin
                    if (det_valid) begin
                        if (idx_q == '0) begin
                            ramp_q <= '0;
                            st_q   <= ST_IDLE;
                        end else begin
                            ramp_q <= shape_lvl;
                            idx_q  <= idx_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Drive the ports from the state registers.
    always_comb begin
        ramp_code   = ramp_q;
        atten_code  = att_q;
        loop_state  = st_q;
        mode_active = mode_q;
    end
endmodule

// File: rtl/bpr_checker.sv
// Property checker for burst_pwr_loop, attached by bind.
module bpr_checker #(
    parameter int DAC_W  = 10,
    parameter int ATT_W  = 4,
    parameter int PSK_DC = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_valid,
    input logic [1:0]       loop_state,
    input logic [DAC_W-1:0] ramp_code,
    input logic [ATT_W-1:0] atten_code,
    input logic             mode_active
);
    // R1: idle always presents a zero ramp code.
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == 2'd0) |-> (ramp_code == '0));

    // R2: from idle only ramp-up can follow.
    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == 2'd0) |=> (loop_state == 2'd0 || loop_state == 2'd1));

    // R3: the rising profile never descends.
    assert_up_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == 2'd1) |=> (loop_state != 2'd1 || ramp_code >= $past(ramp_code)));

    // R4: the falling profile never rises.
    assert_down_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == 2'd3) |=> (ramp_code <= $past(ramp_code)));

    // R6: 8PSK hold keeps the fixed DC code.
    assert_psk_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == 2'd2 && mode_active) |-> (ramp_code == DAC_W'(PSK_DC)));

    // R6: the attenuator moves at most one step, except the clear to zero.
    assert_att_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_code == $past(atten_code)) || (atten_code == '0) ||
        ({1'b0, atten_code} == {1'b0, $past(atten_code)} + 1'b1) ||
        ({1'b0, atten_code} + 1'b1 == {1'b0, $past(atten_code)}));

    // R7: a GMSK burst leaves the attenuator at zero.
    assert_gmsk_att_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_active && loop_state != 2'd0) |-> (atten_code == '0));

    // R8: the modulation does not change inside a burst.
    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state != 2'd0 && $past(loop_state) != 2'd0) |-> $stable(mode_active));

    // R10: without a tick the ramp code is unchanged.
    assert_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_valid) |=> $stable(ramp_code));
endmodule

bind burst_pwr_loop bpr_checker #(.DAC_W(DAC_W), .ATT_W(ATT_W), .PSK_DC(PSK_DC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .det_valid   (det_valid),
    .loop_state  (loop_state),
    .ramp_code   (ramp_code),
    .atten_code  (atten_code),
    .mode_active (mode_active)
);

// File: tb/burst_pwr_loop_tb.sv
`timescale 1ns/1ps
module burst_pwr_loop_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 0, stop = 0, abort = 0, mod_in = 0, dv = 0;
    logic [2:0] shift = 3'd2;
    logic [9:0] target = 10'd500, det = 10'd0;
    logic [9:0] ramp;
    logic [3:0] att;
    logic [1:0] st;
    logic       mode;

    int checks = 0, errors = 0;
    bit done = 0;
    // reference model state
    int m_st, m_idx, m_base, m_ramp, m_att, m_mode;

    always #2 clk = ~clk;

    burst_pwr_loop u_dut (
        .clk(clk), .rst_n(rst_n), .burst_start(start), .burst_stop(stop),
        .burst_abort(abort), .mod_8psk(mod_in), .gain_shift(shift),
        .target_code(target), .det_valid(dv), .det_sample(det),
        .ramp_code(ramp), .atten_code(att), .loop_state(st), .mode_active(mode)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int shape(input int b, input int k);
        return (b * (k + 1) * (k + 1)) / 256;
    endfunction

    task automatic model_reset();
        m_st = 0; m_idx = 0; m_base = 0; m_ramp = 0; m_att = 0; m_mode = 0;
    endtask

    // Next model state from the requirements, for the inputs now applied.
    task automatic model_step();
        int e, r;
        case (m_st)
            0: if (start) begin
                m_st = 1; m_idx = 0; m_mode = mod_in; m_att = 0;
                m_base = mod_in ? 512 : 600;
            end
            1: if (abort) begin
                m_st = 3; m_base = m_ramp; m_idx = 15;
            end else if (dv) begin
                m_ramp = shape(m_base, m_idx);
                if (m_idx == 15) m_st = 2; else m_idx++;
            end
            2: if (stop || abort) begin
                m_st = 3; m_base = m_ramp; m_idx = 15;
            end else if (dv) begin
                if (m_mode != 0) begin
                    if (det > target && m_att < 15) m_att++;
                    else if (det < target && m_att > 0) m_att--;
                end else begin
                    e = int'(target) - int'(det);
                    r = m_ramp + (e >>> shift);
                    m_ramp = (r < 0) ? 0 : (r > 1023) ? 1023 : r;
                end
            end
            default: if (dv) begin
                if (m_idx == 0) begin m_ramp = 0; m_st = 0; end
                else begin m_ramp = shape(m_base, m_idx - 1); m_idx--; end
            end
        endcase
    endtask

    task automatic compare();
        string rt;
        case (m_st)
            1: rt = "R3";
            2: rt = (m_mode != 0) ? "R6" : "R5";
            default: rt = "R4";
        endcase
        check("R2", "state", st, m_st);
        check("R8", "mode", mode, m_mode);
        check((m_mode != 0) ? "R6" : "R7", "atten", att, m_att);
        check(rt, "ramp", ramp, m_ramp);
    endtask

    // One clock: apply inputs, advance model, compare at the next negedge.
    task automatic cyc(input bit s, input bit p, input bit a, input bit v, input int d);
        start = s; stop = p; abort = a; dv = v; det = 10'(d);
        model_step();
        @(negedge clk);
        compare();
        start = 0; stop = 0; abort = 0; dv = 0;
    endtask

    task automatic tick(input int d);
        cyc(0, 0, 0, 1, d);
    endtask

    initial begin
        int prev_r, prev_a;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "state", st, 0); check("R1", "ramp", ramp, 0);
        check("R1", "atten", att, 0); check("R1", "mode", mode, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
        check("R1", "ramp after release", ramp, 0);

        // GMSK burst. R8: mod_in toggles later are ignored.
        mod_in = 0;
        cyc(0, 1, 1, 1, 0);               // R9: stop/abort/tick in idle ignored
        check("R9", "idle state", st, 0);
        cyc(1, 0, 0, 0, 0);
        check("R2", "enter ramp-up", st, 1);
        for (int k = 0; k < 16; k++) begin
            tick(0);
            if (k == 4) begin
                prev_r = ramp;
                cyc(0, 0, 0, 0, 0);       // R10: no tick
                check("R10", "ramp without tick", ramp, prev_r);
                mod_in = 1;
                cyc(1, 1, 0, 0, 0);       // R2/R9: start and stop in ramp-up ignored
                check("R2", "start ignored", st, 1);
                check("R8", "mode kept", mode, 0);
                mod_in = 0;
            end
        end
        check("R3", "ramp peak GMSK", ramp, 600);
        check("R2", "hold", st, 2);
        target = 500; shift = 2;
        tick(400); tick(700); tick(500); tick(503);
        shift = 0; target = 1023;
        repeat (3) tick(0);
        check("R5", "saturate full", ramp, 1023);
        target = 0;
        repeat (3) tick(1023);
        check("R5", "saturate zero", ramp, 0);
        target = 700; shift = 1;
        repeat (6) tick(100);
        shift = 3; tick(900); tick(300);
        check("R7", "GMSK atten", att, 0);
        prev_r = ramp;
        cyc(0, 1, 0, 1, 0);               // R9: stop together with tick
        check("R9", "stop with tick state", st, 3);
        check("R9", "stop with tick ramp", ramp, prev_r);
        for (int j = 0; j < 16; j++) tick(0);
        check("R4", "back to idle", st, 0);
        check("R4", "ramp zero", ramp, 0);

        // 8PSK burst
        mod_in = 1;
        cyc(1, 0, 0, 0, 0);
        mod_in = 0;
        for (int k = 0; k < 16; k++) begin tick(0); cyc(0, 0, 0, 0, 0); end
        check("R3", "ramp peak 8PSK", ramp, 512);
        target = 300;
        repeat (20) tick(400);
        check("R6", "atten top", att, 15);
        repeat (3) tick(300);
        check("R6", "atten equal", att, 15);
        repeat (20) tick(200);
        check("R6", "atten bottom", att, 0);
        repeat (5) tick(301);
        prev_a = att;
        cyc(0, 0, 1, 1, 900);             // R9: abort with tick in hold
        check("R9", "abort atten", att, prev_a);
        for (int j = 0; j < 16; j++) tick(0);
        check("R6", "atten kept after burst", att, 5);

        // GMSK burst aborted mid ramp-up together with a tick
        cyc(1, 0, 0, 0, 0);
        check("R7", "start clears atten", att, 0);
        for (int k = 0; k < 6; k++) tick(0);
        prev_r = ramp;
        cyc(0, 0, 1, 1, 0);
        check("R9", "abort ramp-up state", st, 3);
        check("R9", "abort ramp-up ramp", ramp, prev_r);
        cyc(0, 0, 1, 0, 0);               // R9: abort in ramp-down ignored
        check("R9", "abort in ramp-down", st, 3);
        for (int j = 0; j < 16; j++) tick(0);
        check("R4", "abort ends idle", st, 0);
        repeat (3) cyc(0, 0, 0, 0, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule